// File: doc/BRIEF.md
# DDR2 command spacing enforcer

This block sits between the command issuer of a DDR2 memory controller and the DRAM command bus. The issuer proposes one command per cycle with a valid/ready handshake, giving a command code and a bank number. The block keeps countdown timers, one set for the whole device and one set for each bank. It raises ready only when the proposed command breaks no minimum spacing rule. Otherwise it stalls the issuer, which must hold valid and the payload steady until the command is taken.

The accepted command appears on the DRAM command outputs in the same cycle it is accepted. In any cycle without an accepted command, the outputs carry a no-op. Each limit is given as a time in picoseconds and is turned into clock cycles at elaboration, with any fraction rounded up. The default clock period is 3000 ps. Write-related limits start from the end of the write data. That point is a fixed number of cycles after the WRITE command, set by a parameter that defaults to 6.

Command codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 write with auto-precharge. Codes 6 and 7 are unused.

Top module: `ddr2_cmd_spacer`

## Requirements
- R1: A no-op (code 0), a write (code 3), a write with auto-precharge (code 5) and the unused codes 6 and 7 are always accepted, even while other commands would stall.
- R2: Two activates to any banks are at least ceil(7500/3000) = 3 cycles apart.
- R3: No activate is accepted unless at least 13 cycles (ceil(37500/3000)) have passed since the fourth most recent accepted activate.
- R4: A read to any bank waits until 6 + ceil(7500/3000) = 9 cycles have passed since the last accepted write or write with auto-precharge to any bank.
- R5: A precharge to a bank waits 3 cycles (ceil(7500/3000)) after a read to that same bank. A read to another bank does not delay it.
- R6: A precharge to a bank waits 6 + ceil(15000/3000) = 11 cycles after a write to that same bank.
- R7: An activate to a bank waits 6 + ceil(15000/3000) + ceil(15000/3000) = 16 cycles after a write with auto-precharge to that bank. Each term is rounded up on its own. Other banks are not delayed by this rule.
- R8: All timers keep counting down while a command is stalled, so time spent waiting counts toward every other rule.
- R9: In the cycle a command with code 0 to 5 is accepted, dram_cmd equals req_cmd and dram_bank equals req_bank. In every other cycle, dram_cmd is 0.
- R10: Reset clears every timer and the activate history, so the first command of any kind after reset is accepted at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Issuer presents a command |
| req_cmd | input | 3 | Proposed command code |
| req_bank | input | 3 | Target bank of the proposed command |
| req_ready | output | 1 | Proposed command meets every spacing rule |
| dram_cmd | output | 3 | Command driven to the DRAM this cycle |
| dram_bank | output | 3 | Bank driven with the command |

## Verification
A wrong timer value or a missed timer load shows up at the ports only as a change in how many cycles a later command stalls. The directed scenarios therefore count stall cycles for each command and compare that count with the exact spacing each rule requires. A counter that loads one cycle too short gives a command accepted one cycle early on the next dependent command. A lost slot in the activate history stays hidden until the fifth activate of a burst, so the window test issues activates back to back. Per-bank mixing, where the wrong bank's timer is checked, shows up when a command to a neighbouring bank is accepted at once.

// File: rtl/ddr2_cs_pkg.sv
package ddr2_cs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_WRA = 3'd5
  } cmd_e;

  // picoseconds to whole cycles, fraction rounded up
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  // auto-precharge write delay: each term rounded on its own
  function automatic int unsigned ap_write_cyc(input int unsigned data_end, input int unsigned wr_ps,
                                               input int unsigned rp_ps, input int unsigned clk_ps);
    return data_end + ps_to_cyc(wr_ps, clk_ps) + ps_to_cyc(rp_ps, clk_ps);
  endfunction

endpackage

// File: rtl/cs_down_timer.sv
// Countdown that reports clear once GAP cycles have passed since the last load.
module cs_down_timer #(
  parameter int unsigned GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic clear
);
  localparam int W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [W-1:0] LD = W'((GAP > 0) ? GAP - 1 : 0);

  logic [W-1:0] cnt;
  logic [W-1:0] dec;

  assign dec   = (cnt == '0) ? '0 : cnt - 1'b1;
  assign clear = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load && LD >= dec) cnt <= LD;
    else                        cnt <= dec;
  end
endmodule

// File: rtl/cs_act_window.sv
// Rolling history of the last LIMIT activates as countdowns; oldest blocks when live.
module cs_act_window #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned GAP   = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  output logic open
);
  localparam int W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [W-1:0] LD = W'((GAP > 0) ? GAP - 1 : 0);

  logic [W-1:0] slot [LIMIT];

  function automatic logic [W-1:0] dec(input logic [W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign open = (slot[LIMIT-1] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LIMIT; i++) slot[i] <= '0;
    end else if (push) begin
      slot[0] <= LD;
      for (int i = 1; i < LIMIT; i++) slot[i] <= dec(slot[i-1]);
    end else begin
      for (int i = 0; i < LIMIT; i++) slot[i] <= dec(slot[i]);
    end
  end
endmodule

// File: rtl/cs_bank_guard.sv
// Per-bank timers: read-to-precharge, write recovery, auto-precharge write delay.
module cs_bank_guard #(
  parameter int unsigned RTP_CYC = 3,
  parameter int unsigned WREC_CYC = 11,
  parameter int unsigned DAL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wra_hit,
  output logic pre_ok,
  output logic act_ok
);
  logic rtp_clear, wrec_clear;

  cs_down_timer #(.GAP(RTP_CYC)) u_rtp (
    .clk(clk), .rst_n(rst_n), .load(rd_hit), .clear(rtp_clear));

  cs_down_timer #(.GAP(WREC_CYC)) u_wrec (
    .clk(clk), .rst_n(rst_n), .load(wr_hit), .clear(wrec_clear));

  cs_down_timer #(.GAP(DAL_CYC)) u_dal (
    .clk(clk), .rst_n(rst_n), .load(wra_hit), .clear(act_ok));

  assign pre_ok = rtp_clear && wrec_clear;
endmodule

// File: rtl/ddr2_cmd_spacer.sv
module ddr2_cmd_spacer
  import ddr2_cs_pkg::*;
#(
  parameter int unsigned CLK_PS      = 3000,
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned ACT_LIMIT   = 4,
  parameter int unsigned WDATA_END   = 6,
  parameter int unsigned T_RRD_PS    = 7500,
  parameter int unsigned T_FAW_PS    = 37500,
  parameter int unsigned T_WTR_PS    = 7500,
  parameter int unsigned T_RTP_PS    = 7500,
  parameter int unsigned T_WR_PS     = 15000,
  parameter int unsigned T_RP_PS     = 15000,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  output logic              req_ready,
  output logic [2:0]        dram_cmd,
  output logic [BANK_W-1:0] dram_bank
);
  localparam int unsigned RRD_CYC  = ps_to_cyc(T_RRD_PS, CLK_PS);
  localparam int unsigned FAW_CYC  = ps_to_cyc(T_FAW_PS, CLK_PS);
  localparam int unsigned WTR_CYC  = WDATA_END + ps_to_cyc(T_WTR_PS, CLK_PS);
  localparam int unsigned RTP_CYC  = ps_to_cyc(T_RTP_PS, CLK_PS);
  localparam int unsigned WREC_CYC = WDATA_END + ps_to_cyc(T_WR_PS, CLK_PS);
  localparam int unsigned DAL_CYC  = ap_write_cyc(WDATA_END, T_WR_PS, T_RP_PS, CLK_PS);

  // decoded proposal
  logic is_act, is_rd, is_wr, is_wra, is_pre, is_known;
  assign is_act   = (req_cmd == CMD_ACT);
  assign is_rd    = (req_cmd == CMD_RD);
  assign is_wr    = (req_cmd == CMD_WR);
  assign is_wra   = (req_cmd == CMD_WRA);
  assign is_pre   = (req_cmd == CMD_PRE);
  assign is_known = (req_cmd <= 3'd5);

  // named acceptance events
  logic fire, act_fire, rd_fire, wr_any_fire, wra_fire;
  assign fire        = req_valid && req_ready;
  assign act_fire    = fire && is_act;
  assign rd_fire     = fire && is_rd;
  assign wr_any_fire = fire && (is_wr || is_wra);
  assign wra_fire    = fire && is_wra;

  // device-wide rules
  logic rrd_clear, faw_open, wtr_clear;

  cs_down_timer #(.GAP(RRD_CYC)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(act_fire), .clear(rrd_clear));

  cs_act_window #(.LIMIT(ACT_LIMIT), .GAP(FAW_CYC)) u_faw (
    .clk(clk), .rst_n(rst_n), .push(act_fire), .open(faw_open));

  cs_down_timer #(.GAP(WTR_CYC)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load(wr_any_fire), .clear(wtr_clear));

  // per-bank rules
  logic [NUM_BANKS-1:0] act_ok_b, pre_ok_b;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = fire && (req_bank == BANK_W'(b));
    cs_bank_guard #(.RTP_CYC(RTP_CYC), .WREC_CYC(WREC_CYC), .DAL_CYC(DAL_CYC)) u_guard (
      .clk(clk), .rst_n(rst_n),
      .rd_hit(hit && is_rd), .wr_hit(hit && (is_wr || is_wra)), .wra_hit(hit && is_wra),
      .pre_ok(pre_ok_b[b]), .act_ok(act_ok_b[b]));
  end

  always_comb begin
    req_ready = 1'b1;
    if (is_act)      req_ready = rrd_clear && faw_open && act_ok_b[req_bank];
    else if (is_rd)  req_ready = wtr_clear;
    else if (is_pre) req_ready = pre_ok_b[req_bank];
  end

  assign dram_cmd  = (fire && is_known) ? req_cmd  : 3'(CMD_NOP);
  assign dram_bank = (fire && is_known) ? req_bank : '0;
endmodule

// File: rtl/ddr2_cmd_spacer_chk.sv
module ddr2_cmd_spacer_chk #(
  parameter int unsigned RRD_CYC   = 1,
  parameter int unsigned FAW_CYC   = 1,
  parameter int unsigned WTR_CYC   = 1,
  parameter int unsigned ACT_LIMIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_cmd,
  input logic       req_ready,
  input logic       act_fire,
  input logic       rd_fire,
  input logic       wr_any_fire
);
  logic [31:0] cyc, since_act, since_wr, n_act;
  logic        seen_act, seen_wr;
  logic [31:0] hist [ACT_LIMIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0; since_act <= '0; since_wr <= '0; n_act <= '0;
      seen_act <= 1'b0; seen_wr <= 1'b0;
      for (int i = 0; i < ACT_LIMIT; i++) hist[i] <= '0;
    end else begin
      cyc <= cyc + 1;
      since_act <= act_fire ? 32'd1 : ((since_act == '1) ? since_act : since_act + 1);
      since_wr  <= wr_any_fire ? 32'd1 : ((since_wr == '1) ? since_wr : since_wr + 1);
      if (act_fire) seen_act <= 1'b1;
      if (wr_any_fire) seen_wr <= 1'b1;
      if (act_fire) begin
        hist[0] <= cyc;
        for (int i = 1; i < ACT_LIMIT; i++) hist[i] <= hist[i-1];
        if (n_act < ACT_LIMIT) n_act <= n_act + 1;
      end
    end
  end

  a_r1_free_cmd_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(req_cmd == 3'd1 || req_cmd == 3'd2 || req_cmd == 3'd4) |-> req_ready);

  a_r2_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire && seen_act |-> since_act >= RRD_CYC);

  a_r3_act_window: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire && (n_act == ACT_LIMIT) |-> (cyc - hist[ACT_LIMIT-1]) >= FAW_CYC);

  a_r4_write_to_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && seen_wr |-> since_wr >= WTR_CYC);
endmodule

bind ddr2_cmd_spacer ddr2_cmd_spacer_chk #(
  .RRD_CYC(RRD_CYC), .FAW_CYC(FAW_CYC), .WTR_CYC(WTR_CYC), .ACT_LIMIT(ACT_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_ready(req_ready),
  .act_fire(act_fire), .rd_fire(rd_fire), .wr_any_fire(wr_any_fire)
);

// File: tb/ddr2_cmd_spacer_bench.sv
module ddr2_cmd_spacer_bench;
  localparam int CLK = 3000;
  localparam int DE  = 6;

  function automatic int cyc(input int ps);
    return (ps + CLK - 1) / CLK;
  endfunction

  localparam int RRD  = cyc(7500);
  localparam int FAW  = cyc(37500);
  localparam int WTR  = DE + cyc(7500);
  localparam int RTP  = cyc(7500);
  localparam int WREC = DE + cyc(15000);
  localparam int DAL  = DE + cyc(15000) + cyc(15000);

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, req_ready;
  logic [2:0] req_cmd = 3'd0, req_bank = 3'd0, dram_cmd, dram_bank;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ddr2_cmd_spacer u_ddr2_cmd_spacer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
    .req_ready(req_ready), .dram_cmd(dram_cmd), .dram_bank(dram_bank));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // present a command, count stall cycles, check the bus when it is taken
  task automatic issue(input logic [2:0] c, input logic [2:0] b, input int exp_wait, input string req);
    int waited = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = b;
    #1;
    while (!req_ready && waited < 200) begin
      @(negedge clk); #1; waited++;
    end
    check(waited == exp_wait, req, waited, exp_wait);
    check(dram_cmd == ((c <= 3'd5) ? c : 3'd0), "R9 cmd", int'(dram_cmd), int'((c <= 3'd5) ? c : 3'd0));
    if (c <= 3'd5) check(dram_bank == b, "R9 bank", int'(dram_bank), int'(b));
    @(posedge clk); #1;
    req_valid = 1'b0; req_cmd = 3'd0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1 check(dram_cmd == 3'd0, "R10 idle bus", int'(dram_cmd), 0);
    issue(3'd1, 3'd0, 0, "R10 first act");
    issue(3'd1, 3'd1, RRD - 1, "R2 act gap");
    do_reset();
    issue(3'd1, 3'd2, 0, "R10 timers cleared");
    issue(3'd4, 3'd2, 0, "R10 first pre");
  endtask

  task automatic t_free();
    idle(20);
    issue(3'd1, 3'd0, 0, "R1 setup act");
    issue(3'd0, 3'd0, 0, "R1 nop in stall");
    issue(3'd7, 3'd3, 0, "R1 unused code");
    issue(3'd3, 3'd1, 0, "R1 write");
    issue(3'd5, 3'd2, 0, "R1 write ap");
    idle(5);
    issue(3'd1, 3'd4, 0, "R2 act after gap");
  endtask

  task automatic t_window();
    idle(20);
    issue(3'd1, 3'd0, 0, "R3 act0");
    issue(3'd1, 3'd1, RRD - 1, "R3 act1");
    issue(3'd1, 3'd2, RRD - 1, "R3 act2");
    issue(3'd1, 3'd3, RRD - 1, "R3 act3");
    issue(3'd1, 3'd4, FAW - 3 * RRD - 1, "R3 fifth act");
  endtask

  task automatic t_wtr();
    idle(20);
    issue(3'd3, 3'd0, 0, "R4 write");
    issue(3'd2, 3'd1, WTR - 1, "R4 read other bank");
    idle(20);
    issue(3'd3, 3'd0, 0, "R4 write");
    idle(4);
    issue(3'd2, 3'd0, WTR - 5, "R4 read after idle");
    idle(20);
    issue(3'd5, 3'd6, 0, "R4 write ap");
    issue(3'd2, 3'd5, WTR - 1, "R4 read after write ap");
  endtask

  task automatic t_rtp();
    idle(20);
    issue(3'd2, 3'd2, 0, "R5 read");
    issue(3'd4, 3'd3, 0, "R5 pre other bank");
    issue(3'd4, 3'd2, RTP - 2, "R5 pre same bank");
  endtask

  task automatic t_wrec();
    idle(20);
    issue(3'd3, 3'd4, 0, "R6 write");
    issue(3'd4, 3'd5, 0, "R6 pre other bank");
    issue(3'd4, 3'd4, WREC - 2, "R6 pre same bank");
  endtask

  task automatic t_dal();
    idle(20);
    issue(3'd5, 3'd6, 0, "R7 write ap");
    issue(3'd1, 3'd7, 0, "R7 act other bank");
    issue(3'd1, 3'd6, DAL - 2, "R7 act same bank");
  endtask

  task automatic t_stall();
    idle(20);
    issue(3'd3, 3'd0, 0, "R8 write");
    issue(3'd4, 3'd0, WREC - 1, "R8 stalled pre");
    issue(3'd2, 3'd1, 0, "R8 read after stall");
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_free();
    t_window();
    t_wtr();
    t_rtp();
    t_wrec();
    t_dal();
    t_stall();
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule